// File: doc/BRIEF.md
# Dual-Channel Serial Gain Control Register with Fast Attack

This block is a three-wire serial slave that holds one gain control register for each of two channels. A host selects a channel by pulling its active-low select low. It then sends one 16-bit frame, most significant bit first. The slave samples the data line on rising serial clock edges and drives it on falling edges. The data line is shared by reads and writes. At the pad it is split into an input, an output and an output enable, and the tri-state buffer lives outside the block. When both selects are low together, a write frame updates both registers with the same data.

Bit 15 of each frame selects the direction. A value of 0 means write and a value of 1 means read. On a write, the register stores bits 7:6 as the fast-attack step field and bits 5:0 as the gain code, and ignores bits 14:8. On a read, the slave returns the selected register on the data line during the rest of the frame. A read frame never changes a register, so each new frame that carries bit 15 low puts the interface back in write mode.

Each channel has a fast-attack input. While that input is high, the channel's output code increases by extra attenuation set by its step field. The output saturates at the largest code. One code step equals 0.5 dB, so step field values 0, 1, 2 and 3 add 4, 8, 16 and 32 codes, which is 2, 4, 8 and 16 dB. A serial frame cannot be stalled, so the edges carry no valid/ready handshake. The write path inside the block is a single-cycle valid strobe with no back-pressure. All pins are sampled in the system clock domain and must be synchronous to it.

Top module: `dual_gain_spi`

## Requirements
- R1: After reset, both registers hold zero, every gain_code field reads 0 while fast attack is low, and sdio_oe is low.
- R2: A write frame has bit 15 equal to 0, is sent MSB first and has exactly 16 rising sclk edges while a select is low. It loads bits 7:6 (fast-attack field) and bits 5:0 (gain) into the selected channel only, and the other channel is unchanged.
- R3: A frame that ends with other than 16 rising sclk edges, such as 15 or 17, leaves both registers unchanged.
- R4: A write frame sent with both selects low loads the same field values into both registers.
- R5: A read frame has bit 15 equal to 1 and exactly one select low. On the falling sclk edges that follow rising edges 1 to 15, sdio_out presents register bits 14 down to 0, the word being {7'b0, fast-attack field, gain}. sdio_oe is high from the first of those falling edges until the select rises, and the register is unchanged.
- R6: A read frame sent with both selects low keeps sdio_oe low throughout and changes no register.
- R7: With fa_in[c] low, gain_code field c equals the stored gain. With fa_in[c] high, it equals min(63, gain + (4 << field)). Channel c occupies gain_code[6c+5:6c].
- R8: Bits 14:8 of a write frame are ignored and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idle low, sampled by clk |
| cs_n | input | NCH | Active-low channel selects, bit c selects channel c |
| sdio_in | input | 1 | Serial data from the shared pad |
| sdio_out | output | 1 | Serial data to the shared pad |
| sdio_oe | output | 1 | Pad output enable for sdio_out |
| fa_in | input | NCH | Fast-attack request per channel |
| gain_code | output | NCH*GAIN_W | Effective gain code per channel, 6 bits each |

## Verification
The bench builds the block with its default two channels and 6-bit codes. Because the code space is this small, it can write every combination of gain value and step field. Each combination goes to one channel, the other channel or both, and the bench checks every output with fast attack low and high against an arithmetic model, which reaches each saturation corner. Read-back is exercised on a regular subset of these states. The bench also covers short and long frames, and broadcast reads, where the output enable must stay low.

// File: rtl/dgs_pkg.sv
package dgs_pkg;
  localparam int FRAME_W  = 16;
  localparam int GAIN_W   = 6;
  localparam int STEP_W   = 2;
  localparam int RD_W     = FRAME_W - 1;
  localparam int CNT_W    = $clog2(FRAME_W + 2);
  localparam int FA_BASE  = 4;

  typedef struct packed {
    logic [STEP_W-1:0] step;
    logic [GAIN_W-1:0] gain;
  } chan_reg_t;

  function automatic logic [GAIN_W-1:0] fa_code(input logic [GAIN_W-1:0] g,
                                                input logic [STEP_W-1:0] s);
    logic [GAIN_W+1:0] add;
    logic [GAIN_W+1:0] sum;
    add = (GAIN_W+2)'(FA_BASE) << s;
    sum = {2'b00, g} + add;
    if (sum > (GAIN_W+2)'({GAIN_W{1'b1}})) fa_code = {GAIN_W{1'b1}};
    else fa_code = sum[GAIN_W-1:0];
  endfunction
endpackage

// File: rtl/dgs_spi_frontend.sv
module dgs_spi_frontend
  import dgs_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic [NCH-1:0]       cs_n,
  input  logic                 sdio_in,
  output logic                 sdio_out,
  output logic                 sdio_oe,
  output logic [NCH-1:0]       rd_sel,
  input  logic [RD_W-1:0]      rd_word,
  output logic                 wr_valid,
  output logic [NCH-1:0]       wr_mask,
  output logic [FRAME_W-1:0]   wr_data
);
  logic               sclk_q;
  logic               active;
  logic               reading;
  logic [NCH-1:0]     mask;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;
  logic [RD_W-1:0]    out_sh;

  wire rise      = sclk & ~sclk_q;
  wire fall      = ~sclk & sclk_q;
  wire all_high  = &cs_n;
  wire [NCH-1:0] mask_nx = mask | ~cs_n;
  wire single    = $onehot(mask_nx);

  assign rd_sel = mask_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      active   <= 1'b0;
      reading  <= 1'b0;
      mask     <= '0;
      cnt      <= '0;
      shreg    <= '0;
      out_sh   <= '0;
      sdio_out <= 1'b0;
      sdio_oe  <= 1'b0;
      wr_valid <= 1'b0;
      wr_mask  <= '0;
      wr_data  <= '0;
    end else begin
      sclk_q   <= sclk;
      wr_valid <= 1'b0;
      if (!active) begin
        if (!all_high) begin
          active  <= 1'b1;
          mask    <= ~cs_n;
          cnt     <= '0;
          reading <= 1'b0;
          sdio_oe <= 1'b0;
        end
      end else if (all_high) begin
        active   <= 1'b0;
        reading  <= 1'b0;
        sdio_oe  <= 1'b0;
        wr_valid <= (cnt == CNT_W'(FRAME_W)) && !shreg[FRAME_W-1];
        wr_mask  <= mask;
        wr_data  <= shreg;
      end else begin
        mask <= mask_nx;
        if (rise) begin
          shreg <= {shreg[FRAME_W-2:0], sdio_in};
          if (cnt != CNT_W'(FRAME_W + 1)) cnt <= cnt + 1'b1;
          if (cnt == '0 && sdio_in && single) begin
            reading <= 1'b1;
            out_sh  <= rd_word;
          end
        end
        if (!single) begin
          reading <= 1'b0;
          sdio_oe <= 1'b0;
        end else if (fall && reading) begin
          sdio_oe  <= 1'b1;
          sdio_out <= out_sh[RD_W-1];
          out_sh   <= {out_sh[RD_W-2:0], 1'b0};
        end
      end
    end
  end

  // R5
  drive_only_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> (active && reading));
  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> $onehot(mask));
  // R3
  strobe_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (!active && $past(active)));
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_W + 1));
endmodule

// File: rtl/dgs_fast_attack.sv
module dgs_fast_attack
  import dgs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  chan_reg_t         cfg,
  input  logic              fa_on,
  output logic [GAIN_W-1:0] code
);
  assign code = fa_on ? fa_code(cfg.gain, cfg.step) : cfg.gain;

  // R7
  fa_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fa_on |-> (code > cfg.gain || code == {GAIN_W{1'b1}}));
  // R7
  fa_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fa_on |-> (code == cfg.gain));
endmodule

// File: rtl/dgs_reg_bank.sv
module dgs_reg_bank
  import dgs_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic [NCH-1:0]        wr_mask,
  input  logic [FRAME_W-1:0]    wr_data,
  input  logic [NCH-1:0]        rd_sel,
  output logic [RD_W-1:0]       rd_word,
  output chan_reg_t [NCH-1:0]   regs
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[c] <= '0;
      else if (wr_valid && wr_mask[c])
        regs[c] <= wr_data[STEP_W+GAIN_W-1:0];
    end

    // R2
    hold_unless_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_valid && wr_mask[c]) |=> $stable(regs[c]));
  end

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NCH; c++)
      if (rd_sel[c]) rd_word = RD_W'(regs[c]);
  end
endmodule

// File: rtl/dual_gain_spi.sv
module dual_gain_spi
  import dgs_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic [NCH-1:0]        cs_n,
  input  logic                  sdio_in,
  output logic                  sdio_out,
  output logic                  sdio_oe,
  input  logic [NCH-1:0]        fa_in,
  output logic [NCH*GAIN_W-1:0] gain_code
);
  logic                 wr_valid;
  logic [NCH-1:0]       wr_mask;
  logic [FRAME_W-1:0]   wr_data;
  logic [NCH-1:0]       rd_sel;
  logic [RD_W-1:0]      rd_word;
  chan_reg_t [NCH-1:0]  regs;

  dgs_spi_frontend #(.NCH(NCH)) fe_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .rd_sel(rd_sel), .rd_word(rd_word),
    .wr_valid(wr_valid), .wr_mask(wr_mask), .wr_data(wr_data)
  );

  dgs_reg_bank #(.NCH(NCH)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_mask(wr_mask),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_word(rd_word), .regs(regs)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_fa
    dgs_fast_attack fa_i (
      .clk(clk), .rst_n(rst_n), .cfg(regs[c]), .fa_on(fa_in[c]),
      .code(gain_code[c*GAIN_W +: GAIN_W])
    );
  end
endmodule

// File: tb/dual_gain_spi_tb.sv
module dual_gain_spi_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic [1:0]  cs_n = 2'b11;
  logic        sdio_in = 1'b0;
  logic        sdio_out;
  logic        sdio_oe;
  logic [1:0]  fa_in = 2'b00;
  logic [11:0] gain_code;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_gain_spi #(.NCH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .fa_in(fa_in), .gain_code(gain_code)
  );

  function automatic logic [5:0] exp_code(input logic [7:0] r, input logic fa);
    int s;
    if (!fa) return r[5:0];
    s = int'(r[5:0]) + (4 << r[7:6]);
    return (s > 63) ? 6'd63 : 6'(s);
  endfunction

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] sel, input logic [15:0] w, input int nbits,
                       output logic [14:0] rd, output bit oe_seen);
    rd = '0;
    oe_seen = 1'b0;
    cs_n = ~sel;
    tick(HALF);
    for (int k = 0; k < nbits; k++) begin
      sdio_in = (k < 16) ? w[15-k] : 1'b0;
      sclk = 1'b0;
      tick(HALF);
      sclk = 1'b1;
      tick(HALF/2);
      if (k >= 1 && k <= 15) rd[15-k] = sdio_out;
      if (sdio_oe) oe_seen = 1'b1;
      tick(HALF/2);
    end
    sclk = 1'b0;
    tick(HALF);
    if (sdio_oe) oe_seen = 1'b1;
    cs_n = 2'b11;
    tick(HALF + 2);
  endtask

  task automatic check_outputs(input string req);
    fa_in = 2'b00;
    tick(1);
    check(req, gain_code[5:0],  exp_code(model[0], 1'b0));
    check(req, gain_code[11:6], exp_code(model[1], 1'b0));
    fa_in = 2'b11;
    tick(1);
    check("R7", gain_code[5:0],  exp_code(model[0], 1'b1));
    check("R7", gain_code[11:6], exp_code(model[1], 1'b1));
    fa_in = 2'b00;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [14:0] rd;
    bit oe;
    model[0] = 8'h00;
    model[1] = 8'h00;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    check("R1", gain_code, 0);
    check("R1", sdio_oe, 0);
    fa_in = 2'b01;
    tick(1);
    check("R1", gain_code[5:0], 4);
    fa_in = 2'b00;

    // R2 R4 R7 R8 sweep over every gain and step value
    for (int g = 0; g < 64; g++) begin
      for (int f = 0; f < 4; f++) begin
        logic [1:0] sel;
        logic [15:0] w;
        int t;
        t = (g + f) % 3;
        sel = (t == 0) ? 2'b01 : (t == 1) ? 2'b10 : 2'b11;
        w = {1'b0, 7'(g * 5 + f + 1), 2'(f), 6'(g)};
        frame(sel, w, 16, rd, oe);
        for (int c = 0; c < 2; c++) if (sel[c]) model[c] = w[7:0];
        check("R2", oe, 0);
        check_outputs((sel == 2'b11) ? "R4" : "R2");
        if (g % 8 == 0) begin
          for (int c = 0; c < 2; c++) begin
            frame(2'(1 << c), 16'h8000, 16, rd, oe);
            // R5 read-back, R8 upper bits zero
            check("R5", rd, {7'b0, model[c]});
            check("R5", oe, 1);
            check("R8", rd[14:8], 0);
          end
          check_outputs("R5");
        end
      end
    end

    // R3 short and long frames are discarded
    frame(2'b01, 16'h0035, 15, rd, oe);
    check_outputs("R3");
    frame(2'b10, 16'h00C7, 17, rd, oe);
    check_outputs("R3");
    frame(2'b01, 16'h0000, 15, rd, oe);
    frame(2'b01, 16'h8000, 16, rd, oe);
    check("R3", rd, {7'b0, model[0]});

    // R6 broadcast read keeps the pad released
    frame(2'b11, 16'h8000, 16, rd, oe);
    check("R6", oe, 0);
    check_outputs("R6");
    frame(2'b11, 16'hFFFF, 16, rd, oe);
    check("R6", oe, 0);
    check_outputs("R6");

    // R5 read after write: new frame with bit 15 low writes again
    frame(2'b10, 16'h009D, 16, rd, oe);
    model[1] = 8'h9D;
    frame(2'b10, 16'h8000, 16, rd, oe);
    check("R5", rd, 15'h009D);
    frame(2'b10, 16'h0041, 16, rd, oe);
    model[1] = 8'h41;
    check_outputs("R5");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule